// File: doc/BRIEF.md
# Opcode-Configured Neural Processing Element

This block is one arithmetic element of a neural-network datapath. A thread controller presents a 4-bit opcode with every operand beat, and the element reconfigures its operator on the fly. It can be a multiply-accumulator for convolution and dense layers, a running maximum or minimum for pooling, or an adder of two activation streams for elementwise shortcut sums. Its three operand inputs are two signed activation ports and one signed weight port.

A window of beats is framed by a first flag and a last flag. The first beat starts a fresh accumulation or comparison, and the last beat closes the window. When the window closes, the 24-bit accumulator is saturated to 16 bits and passed through a post-stage. The post-stage is one of bypass, ReLU, a four-segment piecewise-linear sigmoid, or a hyperbolic tangent built from that sigmoid. The result is registered and flagged valid in the cycle after the last beat.

The 16-bit value entering the post-stage is read as signed fixed point with FB fractional bits (default 8, so 1.0 is 256). The sigmoid and tangent results use the same scale.

Top module: `npe_core`

## Requirements
- R1: `op[1:0]` selects the operator: 0 multiply-accumulate, 1 maximum, 2 minimum, 3 add. `op[3:2]` selects the post-function: 0 bypass, 1 ReLU, 2 sigmoid, 3 tangent. The operator is taken from each beat, and the post-function from the last beat of the window.
- R2: In multiply-accumulate, the window result is the sum of `act_a*wgt` over its beats. A beat with `in_first` high starts the sum from zero, whatever the earlier windows held. `act_b` has no effect.
- R3: In maximum (minimum), the window result is the largest (smallest) `act_a` among its beats. `act_b` and `wgt` have no effect.
- R4: In add, the window result is the sum of `act_a+act_b` over its beats, so a one-beat window yields the elementwise sum. `wgt` has no effect.
- R5: Before the post-stage, the accumulator is saturated to the signed 16-bit range [-32768, 32767].
- R6: ReLU outputs 0 for a negative saturated value and passes other values unchanged. Bypass passes the saturated value unchanged.
- R7: Sigmoid of x, with a=|x| and 1.0=256: it is 128+floor(a/4) for a<256, 160+floor(a/8) for a<608, 216+floor(a/32) for a<1280, and 256 otherwise. For negative x the value is mirrored as 256 minus that value.
- R8: Tangent of x equals 2·sigmoid(2x)−256, with sigmoid as in R7 evaluated without saturating 2x.
- R9: `out_valid` is high exactly in the cycle after a beat carrying both `in_valid` and `in_last`. `result` changes only then. After reset, both read 0.
- R10: Cycles with `in_valid` low leave the window untouched, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand beat present |
| in_first | input | 1 | Beat opens a new window |
| in_last | input | 1 | Beat closes the window |
| op | input | 4 | Operator in [1:0], post-function in [3:2] |
| act_a | input | 8 | Signed activation operand A |
| act_b | input | 8 | Signed activation operand B |
| wgt | input | 8 | Signed weight operand |
| out_valid | output | 1 | Result valid |
| result | output | 16 | Signed fixed-point result |

## Verification
The bench builds the element with its defaults: 8-bit operands, a 24-bit accumulator, a 16-bit output and 8 fractional bits. With these values every one of the 256 codes of `act_a` can be swept under each of the sixteen operator and post-function pairings. With weights of 1, 5 and 16, the products step across all four sigmoid segments, their breakpoints and both mirrored halves. Three-beat windows with full-scale products exceed the 16-bit range in both directions, so the saturation is exercised. Windows with idle beats between their operand beats show that those beats are ignored.

// File: rtl/npe_pkg.sv
package npe_pkg;

    typedef enum logic [1:0] {
        OPR_MAC = 2'd0,
        OPR_MAX = 2'd1,
        OPR_MIN = 2'd2,
        OPR_ADD = 2'd3
    } opr_e;

    typedef enum logic [1:0] {
        PF_PASS = 2'd0,
        PF_RELU = 2'd1,
        PF_SIG  = 2'd2,
        PF_TANH = 2'd3
    } post_e;

    // Post-function occupies the upper two bits, operator the lower two.
    typedef struct packed {
        post_e post;
        opr_e  opr;
    } opcode_t;

    localparam int NPE_DW = 8;
    localparam int NPE_AW = 24;
    localparam int NPE_OW = 16;
    localparam int NPE_FB = 8;

endpackage

// File: rtl/npe_combine.sv
module npe_combine #(
    parameter int DW = npe_pkg::NPE_DW,
    parameter int AW = npe_pkg::NPE_AW
) (
    input  npe_pkg::opr_e         opr,
    input  logic                  first,
    input  logic signed [DW-1:0]  a,
    input  logic signed [DW-1:0]  b,
    input  logic signed [DW-1:0]  w,
    input  logic signed [AW-1:0]  acc_q,
    output logic signed [AW-1:0]  acc_d
);
    import npe_pkg::*;

    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic signed [DW:0]   pair;
    logic signed [AW-1:0] prod_x, pair_x, a_x, base;

    assign prod   = a * w;
    assign pair   = DW'(a) + DW'(b) + (DW+1)'(0);
    assign prod_x = AW'(prod);
    assign pair_x = AW'(pair);
    assign a_x    = AW'(a);
    assign base   = first ? '0 : acc_q;

    always_comb begin
        case (opr)
            OPR_MAC: acc_d = base + prod_x;
            OPR_ADD: acc_d = base + pair_x;
            OPR_MAX: acc_d = (first || (a_x > acc_q)) ? a_x : acc_q;
            default: acc_d = (first || (a_x < acc_q)) ? a_x : acc_q;
        endcase
    end
endmodule

// File: rtl/npe_sat.sv
module npe_sat #(
    parameter int AW = npe_pkg::NPE_AW,
    parameter int OW = npe_pkg::NPE_OW
) (
    input  logic signed [AW-1:0] x,
    output logic signed [OW-1:0] y
);
    generate
        if (AW > OW) begin : g_clip
            localparam int HW = AW - OW + 1;
            logic [HW-1:0] head;
            logic          fits;
            assign head = x[AW-1:OW-1];
            assign fits = (head == '0) || (head == '1);
            always_comb begin
                if (fits)
                    y = x[OW-1:0];
                else if (x[AW-1])
                    y = {1'b1, {(OW-1){1'b0}}};
                else
                    y = {1'b0, {(OW-1){1'b1}}};
            end
        end else begin : g_wide
            assign y = OW'(x);
        end
    endgenerate
endmodule

// File: rtl/npe_post.sv
module npe_post #(
    parameter int OW = npe_pkg::NPE_OW,
    parameter int FB = npe_pkg::NPE_FB
) (
    input  npe_pkg::post_e        post,
    input  logic signed [OW-1:0]  x,
    output logic signed [OW-1:0]  y
);
    import npe_pkg::*;

    localparam int XW = OW + 2;
    localparam int ONE_I = 1 << FB;
    localparam logic signed [XW-1:0] ONE = XW'(ONE_I);
    localparam logic signed [XW-1:0] BP1 = XW'(ONE_I);
    localparam logic signed [XW-1:0] BP2 = XW'((19 * ONE_I) / 8);
    localparam logic signed [XW-1:0] BP3 = XW'(5 * ONE_I);
    localparam logic signed [XW-1:0] C0  = XW'(ONE_I / 2);
    localparam logic signed [XW-1:0] C1  = XW'((5 * ONE_I) / 8);
    localparam logic signed [XW-1:0] C2  = XW'((27 * ONE_I) / 32);

    function automatic logic signed [XW-1:0] sig_pwl(input logic signed [XW-1:0] v);
        logic signed [XW-1:0] mag;
        logic signed [XW-1:0] pos;
        mag = v[XW-1] ? -v : v;
        if (mag < BP1)
            pos = C0 + (mag >>> 2);
        else if (mag < BP2)
            pos = C1 + (mag >>> 3);
        else if (mag < BP3)
            pos = C2 + (mag >>> 5);
        else
            pos = ONE;
        return v[XW-1] ? (ONE - pos) : pos;
    endfunction

    logic signed [XW-1:0] x_w, x_dbl, sig_v, sig_dbl, tanh_v;

    assign x_w     = XW'(x);
    assign x_dbl   = x_w <<< 1;
    assign sig_v   = sig_pwl(x_w);
    assign sig_dbl = sig_pwl(x_dbl);
    assign tanh_v  = (sig_dbl <<< 1) - ONE;

    always_comb begin
        case (post)
            PF_PASS: y = x;
            PF_RELU: y = x[OW-1] ? '0 : x;
            PF_SIG:  y = OW'(sig_v);
            default: y = OW'(tanh_v);
        endcase
    end
endmodule

// File: rtl/npe_core.sv
module npe_core #(
    parameter int DW = npe_pkg::NPE_DW,
    parameter int AW = npe_pkg::NPE_AW,
    parameter int OW = npe_pkg::NPE_OW,
    parameter int FB = npe_pkg::NPE_FB
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_first,
    input  logic                 in_last,
    input  logic [3:0]           op,
    input  logic signed [DW-1:0] act_a,
    input  logic signed [DW-1:0] act_b,
    input  logic signed [DW-1:0] wgt,
    output logic                 out_valid,
    output logic signed [OW-1:0] result
);
    import npe_pkg::*;

    opcode_t              oc;
    logic signed [AW-1:0] acc_q, acc_d;
    logic signed [OW-1:0] sat_v, post_v;
    logic                 close;

    assign oc    = opcode_t'(op);
    assign close = in_valid && in_last;

    npe_combine #(.DW(DW), .AW(AW)) u_comb (
        .opr   (oc.opr),
        .first (in_first),
        .a     (act_a),
        .b     (act_b),
        .w     (wgt),
        .acc_q (acc_q),
        .acc_d (acc_d)
    );

    npe_sat #(.AW(AW), .OW(OW)) u_sat (
        .x (acc_d),
        .y (sat_v)
    );

    npe_post #(.OW(OW), .FB(FB)) u_post (
        .post (oc.post),
        .x    (sat_v),
        .y    (post_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= close;
            if (in_valid)
                acc_q <= acc_d;
            if (close)
                result <= post_v;
        end
    end
endmodule

// File: rtl/npe_core_chk.sv
module npe_core_chk #(
    parameter int DW = 8,
    parameter int OW = 16,
    parameter int FB = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_first,
    input logic                 in_last,
    input logic [3:0]           op,
    input logic signed [DW-1:0] act_a,
    input logic signed [DW-1:0] act_b,
    input logic                 out_valid,
    input logic signed [OW-1:0] result
);
    localparam int ONE = 1 << FB;

    logic close;
    assign close = in_valid && in_last;

    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (rst)
        close |=> out_valid);

    assert_valid_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !close |=> !out_valid);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !close |=> $stable(result));

    assert_relu_nonneg_R6: assert property (@(posedge clk) disable iff (rst)
        (close && op[3:2] == 2'd1) |=> !result[OW-1]);

    assert_sig_range_R7: assert property (@(posedge clk) disable iff (rst)
        (close && op[3:2] == 2'd2) |=> ($signed(result) >= 0 && $signed(result) <= ONE));

    assert_tanh_range_R8: assert property (@(posedge clk) disable iff (rst)
        (close && op[3:2] == 2'd3) |=> ($signed(result) >= -ONE && $signed(result) <= ONE));

    assert_add_single_R4: assert property (@(posedge clk) disable iff (rst)
        (close && in_first && op == 4'd3) |=>
        (int'($signed(result)) == int'($past(act_a)) + int'($past(act_b))));
endmodule

bind npe_core npe_core_chk #(.DW(DW), .OW(OW), .FB(FB)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_last   (in_last),
    .op        (op),
    .act_a     (act_a),
    .act_b     (act_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/npe_core_test.sv
module npe_core_test;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_first = 1'b0;
    logic              in_last = 1'b0;
    logic [3:0]        op = 4'd0;
    logic signed [7:0] act_a = '0;
    logic signed [7:0] act_b = '0;
    logic signed [7:0] wgt = '0;
    logic              out_valid;
    logic signed [15:0] result;

    int vecs = 0;
    int errs = 0;
    bit done = 0;

    always #10 clk = ~clk;

    npe_core uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .op(op), .act_a(act_a), .act_b(act_b), .wgt(wgt),
        .out_valid(out_valid), .result(result)
    );

    function automatic int m_sat(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int m_sig(int x);
        int a, p;
        a = (x < 0) ? -x : x;
        if (a < 256)       p = 128 + a / 4;
        else if (a < 608)  p = 160 + a / 8;
        else if (a < 1280) p = 216 + a / 32;
        else               p = 256;
        return (x < 0) ? 256 - p : p;
    endfunction

    function automatic int m_post(int pf, int x);
        case (pf)
            0: return x;
            1: return (x < 0) ? 0 : x;
            2: return m_sig(x);
            default: return 2 * m_sig(2 * x) - 256;
        endcase
    endfunction

    task automatic beat(input int opv, input int a, input int b, input int w,
                        input bit f, input bit l, input bit v);
        op = 4'(opv); act_a = 8'(a); act_b = 8'(b); wgt = 8'(w);
        in_first = f; in_last = l; in_valid = v;
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    endtask

    task automatic check(input string req, input bit exp_v, input int exp_r);
        vecs++;
        if (out_valid !== exp_v || int'(result) != exp_r) begin
            errs++;
            $display("FAIL %s: actual valid=%0b result=%0d, expected valid=%0b result=%0d",
                     req, out_valid, int'(result), exp_v, exp_r);
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog R9: run did not finish, actual hung, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset", 1'b0, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 idle after reset", 1'b0, 0);

        // R1 sweep: every operator and post-function over all act_a codes
        for (int pf = 0; pf < 4; pf++) begin
            for (int opr = 0; opr < 4; opr++) begin
                for (int a = -128; a < 128; a++) begin
                    int b, w, t;
                    b = ((a + 128) * 53 + 5) % 256 - 128;
                    w = (pf >= 2) ? 16 : ((a + 128) * 37 + 11) % 256 - 128;
                    case (opr)
                        0: t = a * w;
                        1, 2: t = a;
                        default: t = a + b;
                    endcase
                    beat(pf * 4 + opr, a, b, w, 1, 1, 1);
                    case (opr)
                        0: check("R1 R2 mac sweep", 1'b1, m_post(pf, m_sat(t)));
                        1: check("R1 R3 max single", 1'b1, m_post(pf, m_sat(t)));
                        2: check("R1 R3 min single", 1'b1, m_post(pf, m_sat(t)));
                        default: check("R1 R4 add sweep", 1'b1, m_post(pf, m_sat(t)));
                    endcase
                end
            end
        end

        // R7 / R8 fine sweeps across segment breakpoints
        for (int k = 0; k < 2; k++) begin
            for (int a = -128; a < 128; a++) begin
                beat(8 + k * 4, a, 0, 1, 1, 1, 1);
                if (k == 0) check("R7 sigmoid w1", 1'b1, m_sig(a));
                else        check("R8 tanh w1", 1'b1, 2 * m_sig(2 * a) - 256);
                beat(8 + k * 4, a, 0, 5, 1, 1, 1);
                if (k == 0) check("R7 sigmoid w5", 1'b1, m_sig(5 * a));
                else        check("R8 tanh w5", 1'b1, 2 * m_sig(10 * a) - 256);
            end
        end

        // R5 saturation, positive and negative
        beat(0, 127, 0, 127, 1, 0, 1);
        check("R9 no valid mid window", 1'b0, 2 * m_sig(10 * 127) - 256);
        beat(0, 127, 0, 127, 0, 0, 1);
        beat(0, 127, 0, 127, 0, 1, 1);
        check("R5 saturate high", 1'b1, 32767);
        beat(0, -128, 0, 127, 1, 0, 1);
        beat(0, -128, 0, 127, 0, 0, 1);
        beat(0, -128, 0, 127, 0, 1, 1);
        check("R5 saturate low", 1'b1, -32768);
        beat(4, -128, 0, 127, 1, 0, 1);
        beat(4, -128, 0, 127, 0, 0, 1);
        beat(4, -128, 0, 127, 0, 1, 1);
        check("R6 relu of saturated negative", 1'b1, 0);

        // R3 multi-beat with idle beats carrying garbage (R10)
        beat(1, 3, 99, 50, 1, 0, 1);
        beat(1, 120, -5, 7, 1, 1, 0);
        beat(1, -7, 0, 0, 0, 0, 1);
        beat(0, 100, 100, 100, 1, 1, 0);
        beat(1, 50, -100, 9, 0, 0, 1);
        beat(1, 12, 1, 1, 0, 1, 1);
        check("R3 R10 window max", 1'b1, 50);
        beat(2, 3, 0, 0, 1, 0, 1);
        beat(2, -128, 0, 0, 1, 1, 0);
        beat(2, -7, 60, 2, 0, 0, 1);
        beat(2, 50, 0, 0, 0, 0, 1);
        beat(2, 12, 0, 0, 0, 1, 1);
        check("R3 R10 window min", 1'b1, -7);

        // R4 multi-beat add
        beat(3, 1, 2, 77, 1, 0, 1);
        beat(3, 3, 4, -77, 0, 1, 1);
        check("R4 add window", 1'b1, 10);

        // R2 restart: a new first beat discards the previous sum
        beat(0, 10, 0, 10, 1, 0, 1);
        beat(0, 2, 55, 3, 1, 1, 1);
        check("R2 restart on first", 1'b1, 6);
        beat(0, 20, -3, 20, 1, 0, 1);
        beat(0, 0, 0, 0, 0, 0, 0);
        check("R10 idle keeps result", 1'b0, 6);
        beat(0, -4, 9, 25, 0, 1, 1);
        check("R2 R10 accumulate across idle", 1'b1, 300);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule